// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of an SPI master from a faster module clock. A 13-bit control word selects one of two divide laws. The linear law divides by 2*(N+1), with N an 8-bit field. The power-of-two law divides by 2^(M+1), with M a 4-bit field. While the enable is low, the serial clock rests at a programmable idle level.

Each transition of the serial clock comes with a one-cycle strobe. The strobe marks either the leading edge, which moves away from idle, or the trailing edge, which returns to idle. The shifter uses these strobes to launch and capture data.

The divisor is captured at every half-period boundary, and while the block is disabled. Software can therefore rewrite the control word at any time without producing a shortened pulse.

Top module: `sclk_divgen`

## Requirements
- R1: During reset and in the first cycle after it, `sclk` is 0 and both strobes are 0.
- R2: When `ctl[12]` = 1 (linear law), each half period lasts N+1 module clocks, where N = `ctl[7:0]`.
- R3: When `ctl[12]` = 0 (power-of-two law), each half period lasts 2^M module clocks, where M = `ctl[11:8]`.
- R4: After `en` rises, the first transition of `sclk` comes at the H-th rising edge that samples `en` high, where H is the half-period length. This transition moves away from `idle_lvl`.
- R5: Consecutive half periods have the same length, which gives a 50% duty cycle.
- R6: `lead_stb` is high for exactly the cycle in which `sclk` first leaves `idle_lvl`. `trail_stb` is high for exactly the cycle in which `sclk` returns to it. The two strobes are never high together.
- R7: One cycle after `en` is sampled low, `sclk` equals `idle_lvl`, both strobes are 0, and the half-period count restarts from zero.
- R8: A change to `ctl` while enabled takes effect only from the next half-period boundary. The half period in progress keeps its old length.
- R9: With `idle_lvl` = 1, the clock rests high and its leading edge is a falling edge.
- R10: The field of the law that is not selected has no effect on the serial clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Runs the divider when high |
| ctl | input | 13 | Control word: [7:0] linear N, [11:8] exponent M, [12] law select (1 = linear) |
| idle_lvl | input | 1 | Resting level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on the edge that leaves idle |
| trail_stb | output | 1 | One-cycle strobe on the edge that returns to idle |

## Verification
The main function is driven with several lengths under each law: N = 0, 3 and 6, and M = 0, 2 and 3. These separate an off-by-one in the N+1 term from a wrong shift in the 2^M term, and the smallest settings expose a counter that cannot reload in back-to-back cycles. A run with idle level 1 separates strobes derived from edge polarity from strobes derived from departure from idle. Runs that load garbage into the unused field show that the law select really gates the field. A mid-run rewrite from a 3-cycle to a 5-cycle half period shows whether the new length is taken immediately or at the boundary.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
   // Selects the divide law from the control word's mode bit.
   typedef enum logic {
      LAW_POW2   = 1'b0,
      LAW_LINEAR = 1'b1
   } div_law_e;

   // Width needed to hold the largest half period of either law.
   function automatic int half_width(input int lin_w, input int pow_w);
      int max_exp;
      max_exp = (1 << pow_w) - 1;
      return ((lin_w > max_exp) ? lin_w : max_exp) + 1;
   endfunction
endpackage

// File: rtl/sclk_divlaw.sv
module sclk_divlaw
   import sclk_div_pkg::*;
#(
   parameter int LIN_W = 8,
   parameter int POW_W = 4,
   parameter int CNT_W = half_width(LIN_W, POW_W),
   localparam int CTL_W = LIN_W + POW_W + 1
) (
   input  logic [CTL_W-1:0] ctl,
   output logic [CNT_W-1:0] half_len
);
   div_law_e         law;
   logic [LIN_W-1:0] lin_n;
   logic [POW_W-1:0] pow_m;

   assign law   = div_law_e'(ctl[CTL_W-1]);
   assign lin_n = ctl[LIN_W-1:0];
   assign pow_m = ctl[LIN_W+POW_W-1:LIN_W];

   always_comb begin
      if (law == LAW_LINEAR)
         half_len = CNT_W'(lin_n) + CNT_W'(1);
      else
         half_len = CNT_W'(1) << pow_m;
   end
endmodule

// File: rtl/sclk_halfcnt.sv
module sclk_halfcnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] len_next,
   output logic             boundary,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] len_q
);
   assign boundary = en && (cnt_q == len_q - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         len_q <= CNT_W'(1);
      end else if (!en || boundary) begin
         cnt_q <= '0;
         len_q <= len_next;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/sclk_edgegen.sv
module sclk_edgegen (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic idle_lvl,
   input  logic boundary,
   output logic sclk_q,
   output logic lead_q,
   output logic trail_q
);
   logic at_idle;
   assign at_idle = (sclk_q == idle_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
      end else if (!en) begin
         sclk_q  <= idle_lvl;
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
      end else begin
         if (boundary)
            sclk_q <= ~sclk_q;
         lead_q  <= boundary &&  at_idle;
         trail_q <= boundary && !at_idle;
      end
   end
endmodule

// File: rtl/sclk_divgen.sv
module sclk_divgen
   import sclk_div_pkg::*;
#(
   parameter int LIN_W = 8,
   parameter int POW_W = 4,
   localparam int CTL_W = LIN_W + POW_W + 1,
   localparam int CNT_W = half_width(LIN_W, POW_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CTL_W-1:0] ctl,
   input  logic             idle_lvl,
   output logic             sclk,
   output logic             lead_stb,
   output logic             trail_stb
);
   logic [CNT_W-1:0] len_next;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_q;
   logic             boundary;

   sclk_divlaw #(.LIN_W(LIN_W), .POW_W(POW_W), .CNT_W(CNT_W)) u_law (
      .ctl      (ctl),
      .half_len (len_next)
   );

   sclk_halfcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .len_next (len_next),
      .boundary (boundary),
      .cnt_q    (cnt_q),
      .len_q    (len_q)
   );

   sclk_edgegen u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .idle_lvl (idle_lvl),
      .boundary (boundary),
      .sclk_q   (sclk),
      .lead_q   (lead_stb),
      .trail_q  (trail_stb)
   );
endmodule

// File: rtl/sclk_divgen_chk.sv
module sclk_divgen_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             idle_lvl,
   input logic             sclk,
   input logic             lead_stb,
   input logic             trail_stb,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] len_q
);
   logic past_vld;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_vld <= 1'b0;
      else        past_vld <= 1'b1;
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !past_vld |-> (!lead_stb && !trail_stb));

   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_stb && trail_stb));

   assert_strobe_marks_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_vld && (lead_stb || trail_stb)) |-> (sclk != $past(sclk)));

   assert_edge_has_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_vld && $past(en) && (sclk != $past(sclk))) |-> (lead_stb || trail_stb));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_vld && !$past(en)) |-> (sclk == $past(idle_lvl) && !lead_stb && !trail_stb));

   assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < len_q);

   assert_len_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_vld && $past(en) && !lead_stb && !trail_stb) |-> $stable(len_q));
endmodule

bind sclk_divgen sclk_divgen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .idle_lvl  (idle_lvl),
   .sclk      (sclk),
   .lead_stb  (lead_stb),
   .trail_stb (trail_stb),
   .cnt_q     (cnt_q),
   .len_q     (len_q)
);

// File: tb/sclk_divgen_tb.sv
module sclk_divgen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [12:0] ctl = '0;
   logic        idle_lvl = 1'b0;
   logic        sclk, lead_stb, trail_stb;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sclk_divgen u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .ctl(ctl), .idle_lvl(idle_lvl),
      .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [12:0] lin_ctl(input int n, input int junk);
      return {1'b1, 4'(junk), 8'(n)};
   endfunction

   function automatic logic [12:0] pow_ctl(input int m, input int junk);
      return {1'b0, 4'(m), 8'(junk)};
   endfunction

   // Enables with ctl_a, rewrites to ctl_b after the first sample, and checks
   // every cycle against toggles at h_a, then every h_b cycles.
   task automatic run_seq(input logic [12:0] ctl_a, input logic [12:0] ctl_b,
                          input logic idle, input int h_a, input int h_b,
                          input int nsamp, input string tag);
      int next_t;
      int tog;
      logic exp_s;
      @(negedge clk);
      en = 1'b0; ctl = ctl_a; idle_lvl = idle;
      @(negedge clk);
      @(negedge clk);
      check(sclk == idle && !lead_stb && !trail_stb, {tag, " R7 idle rest"}, int'(sclk), int'(idle));
      en = 1'b1;
      next_t = h_a;
      tog = 0;
      for (int k = 1; k <= nsamp; k++) begin
         bit edge_now;
         @(negedge clk);
         edge_now = (k == next_t);
         if (edge_now) begin
            tog++;
            next_t += h_b;
         end
         exp_s = idle ^ tog[0];
         check(sclk == exp_s, {tag, " sclk level"}, int'(sclk), int'(exp_s));
         check(lead_stb == (edge_now && tog[0]), {tag, " R6 lead strobe"},
               int'(lead_stb), int'(edge_now && tog[0]));
         check(trail_stb == (edge_now && !tog[0]), {tag, " R6 trail strobe"},
               int'(trail_stb), int'(edge_now && !tog[0]));
         if (k == 1) ctl = ctl_b;
      end
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check(sclk == idle && !lead_stb && !trail_stb, {tag, " R7 disable"}, int'(sclk), int'(idle));
   endtask

   task automatic test_reset;
      check(sclk == 1'b0 && !lead_stb && !trail_stb, "R1 in reset", int'(sclk), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(sclk == 1'b0 && !lead_stb && !trail_stb, "R1 after reset", int'(sclk), 0);
   endtask

   task automatic test_linear;
      run_seq(lin_ctl(0, 0), lin_ctl(0, 0), 1'b0, 1, 1, 8,  "R2 N=0");
      run_seq(lin_ctl(3, 0), lin_ctl(3, 0), 1'b0, 4, 4, 20, "R2 R4 R5 N=3");
      run_seq(lin_ctl(6, 0), lin_ctl(6, 0), 1'b0, 7, 7, 30, "R2 N=6");
   endtask

   task automatic test_pow2;
      run_seq(pow_ctl(0, 0), pow_ctl(0, 0), 1'b0, 1, 1, 8,  "R3 M=0");
      run_seq(pow_ctl(2, 0), pow_ctl(2, 0), 1'b0, 4, 4, 20, "R3 R5 M=2");
      run_seq(pow_ctl(3, 0), pow_ctl(3, 0), 1'b0, 8, 8, 36, "R3 M=3");
   endtask

   task automatic test_idle_high;
      run_seq(lin_ctl(1, 0), lin_ctl(1, 0), 1'b1, 2, 2, 12, "R9 idle high");
   endtask

   task automatic test_unused_field;
      run_seq(lin_ctl(2, 15),  lin_ctl(2, 15),  1'b0, 3, 3, 15, "R10 linear junk M");
      run_seq(pow_ctl(1, 255), pow_ctl(1, 255), 1'b0, 2, 2, 12, "R10 pow junk N");
   endtask

   task automatic test_reconfig;
      run_seq(lin_ctl(2, 0), lin_ctl(4, 0), 1'b0, 3, 5, 24, "R8 rewrite mid half");
   endtask

   task automatic test_idle_follow;
      @(negedge clk);
      en = 1'b0; idle_lvl = 1'b1;
      @(negedge clk);
      check(sclk == 1'b1 && !lead_stb && !trail_stb, "R7 follows idle 1", int'(sclk), 1);
      idle_lvl = 1'b0;
      @(negedge clk);
      check(sclk == 1'b0 && !lead_stb && !trail_stb, "R7 follows idle 0", int'(sclk), 0);
   endtask

   initial begin
      test_reset();
      test_linear();
      test_pow2();
      test_idle_high();
      test_unused_field();
      test_reconfig();
      test_idle_follow();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule